// File: doc/BRIEF.md
# Comma-Aligning 10-Bit Deserializer

This block turns a recovered serial bit stream into 10-bit characters. A qualifying enable marks each cycle that carries a new bit. Bits are packed first-in at bit 0, and every tenth bit launches a finished character on the parallel output. A loopback select picks the local transmit serial stream as the source instead of the line input. While loopback is selected, the transmit line output is held low.

When alignment is enabled, the block watches the incoming bits for the positive comma, which is 0011111 in arrival order. On a match it moves the character boundary so that the first comma bit becomes bit 0 of the character being built. That character is launched once its remaining three bits have arrived, and a sync flag is raised alongside it. A comma that already sits on the boundary changes nothing.

Two half-rate byte strobes run in opposite phase. Successive characters are launched alternately on the rising edge of the first strobe and then the second.

Top module: `comma_deser`

## Requirements
- R1: Only cycles with `bit_en_i` high shift in a bit. After reset the first such bit lands in `word_o[0]`, and each group of ten bits appears as one word, the earliest bit at bit 0 and the latest at bit 9.
- R2: With `align_en_i` high, a misaligned comma (arrival order 0,0,1,1,1,1,1, i.e. word bits [6:0] = 7'b1111100) makes the next launched word start with the comma. That word is launched three bits after the seventh comma bit. Any partial word before it is still launched when its tenth bit arrives.
- R3: A comma that already starts on the word boundary causes no realignment. The word carrying it is launched after the usual ten bits, and no extra launch occurs.
- R4: With `align_en_i` low, a comma anywhere in the stream leaves the word boundary unchanged, and `sync_o` stays low.
- R5: `sync_o` is high for a launched word that starts with a comma detected while alignment was enabled, and low for every other word.
- R6: After reset `strb0_o` is 0 and `strb1_o` is 1. Each launch toggles both, so `strb0_o` rises on the 1st, 3rd, 5th... launch and `strb1_o` rises on the 2nd, 4th... launch. `strb1_o` is always the inverse of `strb0_o`.
- R7: With `loopback_i` high, bits are taken from `tx_line_i` and `line_bit_i` is ignored. With it low, bits are taken from `line_bit_i`.
- R8: `tx_line_o` is 0 while `loopback_i` is high, and equals `tx_line_i` otherwise.
- R9: `word_o` and `sync_o` are registered. They change only on the clock edge that launches a word, which is the edge sampling its last bit, and they hold until the next launch.
- R10: Reset clears the word to 0, clears the sync flag, and clears the bit position, so that the first bit after reset is word bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Marks a cycle carrying a new serial bit |
| line_bit_i | input | 1 | Recovered serial bit from the line |
| tx_line_i | input | 1 | Local transmit serial bit |
| loopback_i | input | 1 | Selects the transmit stream as receive source |
| align_en_i | input | 1 | Enables comma detection and realignment |
| tx_line_o | output | 1 | Transmit line, forced low in loopback |
| word_o | output | 10 | Assembled character, bit 0 received first |
| sync_o | output | 1 | High with a comma-aligned word |
| strb0_o | output | 1 | Byte strobe, rises on odd launches |
| strb1_o | output | 1 | Byte strobe, inverse of strb0_o |

## Verification
A word, its sync flag and the strobe toggle all become visible after the same clock edge. For a plain word that is the edge sampling its tenth bit; for a realigned comma word it is the third bit after the comma completes. The monitor samples on the falling edge that follows.

Each expected word is queued before its bits are driven. The monitor pops an entry only when it sees a strobe toggle. Any change of word or flag without a toggle counts as a failure, and so do entries left over at the end.

`tx_line_o` is combinational. It is checked one nanosecond after its inputs are driven.

// File: rtl/cd_pkg.sv
package cd_pkg;
  localparam int unsigned CD_WORD_W    = 10;
  localparam int unsigned CD_COMMA_LEN = 7;
  // comma in arrival order, bit 0 = earliest: 0,0,1,1,1,1,1
  localparam logic [CD_COMMA_LEN-1:0] CD_COMMA = 7'b1111100;
endpackage

// File: rtl/cd_src_sel.sv
module cd_src_sel (
  input  logic loopback_i,
  input  logic line_bit_i,
  input  logic tx_line_i,
  output logic rx_bit_o,
  output logic tx_line_o
);
  always_comb begin
    rx_bit_o  = loopback_i ? tx_line_i : line_bit_i;
    tx_line_o = loopback_i ? 1'b0 : tx_line_i;
  end
endmodule

// File: rtl/cd_comma_det.sv
module cd_comma_det #(
  parameter int unsigned WORD_W    = cd_pkg::CD_WORD_W,
  parameter int unsigned COMMA_LEN = cd_pkg::CD_COMMA_LEN,
  parameter logic [COMMA_LEN-1:0] COMMA = cd_pkg::CD_COMMA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] hist_next_o,
  output logic              match_o
);
  logic [WORD_W-1:0] hist_q;

  // newest bit enters at the top, oldest drifts to bit 0
  always_comb begin
    hist_next_o = {bit_i, hist_q[WORD_W-1:1]};
    match_o     = bit_en_i && (hist_next_o[WORD_W-1 -: COMMA_LEN] == COMMA);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hist_q <= '0;
    else if (bit_en_i) hist_q <= hist_next_o;
  end

  a_r1_hist_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(hist_q));
  a_r1_hist_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i |=> hist_q[WORD_W-1] == $past(bit_i));
endmodule

// File: rtl/cd_word_asm.sv
module cd_word_asm #(
  parameter int unsigned WORD_W    = cd_pkg::CD_WORD_W,
  parameter int unsigned COMMA_LEN = cd_pkg::CD_COMMA_LEN,
  parameter logic [COMMA_LEN-1:0] COMMA = cd_pkg::CD_COMMA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              align_en_i,
  input  logic              match_i,
  input  logic [WORD_W-1:0] hist_next_i,
  output logic [WORD_W-1:0] word_o,
  output logic              sync_o,
  output logic              launch_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] LOAD_POS = CNT_W'(COMMA_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;
  logic             realign;

  always_comb begin
    launch_o = bit_en_i && (cnt_q == LAST_POS);
    realign  = align_en_i && match_i;
  end

  // position counter: next bit index within the word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (bit_en_i) begin
      if (realign)       cnt_q <= LOAD_POS;
      else if (launch_o) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  // comma seen for the word being built
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       seen_q <= 1'b0;
    else if (realign)  seen_q <= 1'b1;
    else if (launch_o) seen_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
      sync_o <= 1'b0;
    end else if (launch_o) begin
      word_o <= hist_next_i;
      sync_o <= seen_q;
    end
  end

  a_r1_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST_POS);
  a_r4_keep_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i && !align_en_i && cnt_q != LAST_POS |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r2_realign_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i && align_en_i && match_i |=> cnt_q == LOAD_POS);
  a_r5_sync_comma: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> word_o[COMMA_LEN-1:0] == COMMA);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !launch_o |=> $stable(word_o) && $stable(sync_o));
endmodule

// File: rtl/cd_strobe_gen.sv
module cd_strobe_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  output logic strb0_o,
  output logic strb1_o
);
  logic ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ph_q <= 1'b0;
    else if (launch_i) ph_q <= ~ph_q;
  end

  assign strb0_o = ph_q;
  assign strb1_o = ~ph_q;

  a_r6_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> strb0_o != $past(strb0_o));
  a_r6_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !launch_i |=> $stable(strb0_o));
endmodule

// File: rtl/comma_deser.sv
module comma_deser
  import cd_pkg::*;
#(
  parameter int unsigned WORD_W    = CD_WORD_W,
  parameter int unsigned COMMA_LEN = CD_COMMA_LEN,
  parameter logic [COMMA_LEN-1:0] COMMA = CD_COMMA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              line_bit_i,
  input  logic              tx_line_i,
  input  logic              loopback_i,
  input  logic              align_en_i,
  output logic              tx_line_o,
  output logic [WORD_W-1:0] word_o,
  output logic              sync_o,
  output logic              strb0_o,
  output logic              strb1_o
);
  logic              rx_bit;
  logic [WORD_W-1:0] hist_next;
  logic              match;
  logic              launch;

  cd_src_sel u_src (
    .loopback_i (loopback_i),
    .line_bit_i (line_bit_i),
    .tx_line_i  (tx_line_i),
    .rx_bit_o   (rx_bit),
    .tx_line_o  (tx_line_o)
  );

  cd_comma_det #(.WORD_W(WORD_W), .COMMA_LEN(COMMA_LEN), .COMMA(COMMA)) u_det (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_en_i    (bit_en_i),
    .bit_i       (rx_bit),
    .hist_next_o (hist_next),
    .match_o     (match)
  );

  cd_word_asm #(.WORD_W(WORD_W), .COMMA_LEN(COMMA_LEN), .COMMA(COMMA)) u_asm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_en_i    (bit_en_i),
    .align_en_i  (align_en_i),
    .match_i     (match),
    .hist_next_i (hist_next),
    .word_o      (word_o),
    .sync_o      (sync_o),
    .launch_o    (launch)
  );

  cd_strobe_gen u_strb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .strb0_o  (strb0_o),
    .strb1_o  (strb1_o)
  );

  a_r8_tx_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loopback_i |-> tx_line_o == 1'b0);
  a_r7_loop_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loopback_i && bit_en_i |=> u_det.hist_q[WORD_W-1] == $past(tx_line_i));
endmodule

// File: tb/comma_deser_test.sv
`timescale 1ns/1ps
module comma_deser_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_en_i = 1'b0, line_bit_i = 1'b0, tx_line_i = 1'b0;
  logic loopback_i = 1'b0, align_en_i = 1'b0;
  logic tx_line_o, sync_o, strb0_o, strb1_o;
  logic [9:0] word_o;

  always #10 clk = ~clk;

  comma_deser uut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .line_bit_i(line_bit_i),
    .tx_line_i(tx_line_i), .loopback_i(loopback_i), .align_en_i(align_en_i),
    .tx_line_o(tx_line_o), .word_o(word_o), .sync_o(sync_o),
    .strb0_o(strb0_o), .strb1_o(strb1_o)
  );

  int checks = 0, errors = 0, n_launch = 0;
  bit done = 1'b0, mon_on = 1'b0;
  logic [10:0] exp_q[$];
  string tag_q[$];
  logic prev_s0, prev_sy;
  logic [9:0] prev_w;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_word(input logic [9:0] w, input logic s, input string tag);
    exp_q.push_back({s, w});
    tag_q.push_back(tag);
  endtask

  task automatic send_bit(input logic b, input int gap);
    @(negedge clk);
    bit_en_i = 1'b1;
    if (loopback_i) begin tx_line_i = b; line_bit_i = ~b; end
    else begin line_bit_i = b; tx_line_i = ~b; end
    @(negedge clk);
    bit_en_i = 1'b0;
    for (int g = 0; g < gap; g++) begin
      line_bit_i = ~line_bit_i;
      tx_line_i  = ~tx_line_i;
      @(negedge clk);
    end
  endtask

  task automatic send_bits(input logic [15:0] v, input int n, input int gap);
    for (int i = 0; i < n; i++) send_bit(v[i], gap);
  endtask

  // monitor: a strobe toggle marks a launch
  always @(negedge clk) begin
    if (mon_on) begin
      if (strb0_o !== prev_s0) begin
        n_launch++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected launch", {22'd0, word_o}, 32'd0);
        end else begin
          logic [10:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(word_o === e[9:0], {t, " word"}, {22'd0, word_o}, {22'd0, e[9:0]});
          chk(sync_o === e[10], {t, " R5 sync"}, {31'd0, sync_o}, {31'd0, e[10]});
          chk(strb0_o === n_launch[0] && strb1_o === ~n_launch[0], "R6 strobe phase",
              {30'd0, strb1_o, strb0_o}, {30'd0, ~n_launch[0], n_launch[0]});
        end
      end else if (word_o !== prev_w || sync_o !== prev_sy) begin
        chk(1'b0, "R9 output changed without launch", {21'd0, sync_o, word_o}, {21'd0, prev_sy, prev_w});
      end
      prev_s0 = strb0_o;
      prev_w  = word_o;
      prev_sy = sync_o;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 / R6 reset state
    chk(word_o === 10'd0, "R10 reset word", {22'd0, word_o}, 32'd0);
    chk(sync_o === 1'b0, "R10 reset sync", {31'd0, sync_o}, 32'd0);
    chk(strb0_o === 1'b0 && strb1_o === 1'b1, "R6 reset strobes", {30'd0, strb1_o, strb0_o}, 32'h2);
    rst_ni = 1'b1;
    prev_s0 = strb0_o; prev_w = word_o; prev_sy = sync_o;
    mon_on = 1'b1;

    // alignment off, plain data incl. a misaligned comma
    expect_word(10'h155, 1'b0, "R1");
    send_bits(16'h0155, 10, 0);
    expect_word(10'h3E5, 1'b0, "R4");
    send_bits(16'h03E5, 10, 2);
    expect_word(10'h2B3, 1'b0, "R1");
    send_bits(16'h02B3, 10, 1);

    // alignment on, comma already on boundary
    align_en_i = 1'b1;
    expect_word(10'h17C, 1'b1, "R3");
    send_bits(16'h017C, 10, 0);
    expect_word(10'h155, 1'b0, "R3");
    send_bits(16'h0155, 10, 0);

    // misaligned comma, realigned
    expect_word(10'h3CA, 1'b0, "R2 partial");
    expect_word(10'h17C, 1'b1, "R2 aligned");
    expect_word(10'h155, 1'b0, "R2 after");
    send_bits(16'h000A, 4, 0);
    send_bits(16'h017C, 10, 1);
    send_bits(16'h0155, 10, 0);

    // alignment off, same misaligned comma ignored
    align_en_i = 1'b0;
    expect_word(10'h3CA, 1'b0, "R4 first");
    expect_word(10'h2A5, 1'b0, "R4 second");
    send_bits(16'h000A, 4, 0);
    send_bits(16'h017C, 10, 0);
    send_bits(16'h002A, 6, 0);

    // loopback
    @(negedge clk);
    loopback_i = 1'b1; tx_line_i = 1'b1;
    #1;
    chk(tx_line_o === 1'b0, "R8 loopback forces low", {31'd0, tx_line_o}, 32'd0);
    expect_word(10'h0F3, 1'b0, "R7 loopback");
    send_bits(16'h00F3, 10, 1);

    @(negedge clk);
    loopback_i = 1'b0; tx_line_i = 1'b1;
    #1;
    chk(tx_line_o === 1'b1, "R8 pass high", {31'd0, tx_line_o}, 32'd1);
    tx_line_i = 1'b0;
    #1;
    chk(tx_line_o === 1'b0, "R8 pass low", {31'd0, tx_line_o}, 32'd0);
    expect_word(10'h2CC, 1'b0, "R7 line");
    send_bits(16'h02CC, 10, 0);

    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R2 missing launches", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule